// File: doc/BRIEF.md
# Memory Operand Address and Segment Resolver

This block forms the 32-bit offset of a memory operand and chooses the segment register that the access goes through. The offset is the wrapping sum of up to three parts. The first is an optional base register. The second is an optional index register shifted left by 0 to 3 places. The third is an optional displacement of 8, 16 or 32 bits, sign-extended before the add. Decoded instruction fields and the eight general register values arrive together with `in_valid`. One cycle later the block presents the offset, a 3-bit segment code and an illegal-index flag, qualified by `out_valid`.

The segment follows fixed rules. Instruction fetches always use the code segment. Stack pushes and pops always use the stack segment. String destinations always use the extra segment. Ordinary data references use the segment named by an override prefix when one is present. Without a prefix, they use the stack segment when the base register is the stack or frame pointer, and the data segment in every other case. The block does not decode instructions, translate segments or check limits.

Top module: `ea_seg_unit`

## Requirements
- R1: `out_offset` equals base + (index << scale) + extended displacement, taken modulo 2^32, with no overflow indication.
- R2: Each part is optional. A base with `base_en`=0, an index with `idx_en`=0, or a displacement with `disp_size`=0 contributes zero.
- R3: `disp_size` selects how the displacement is used: 1 sign-extends `disp[7:0]`, 2 sign-extends `disp[15:0]`, and 3 uses all 32 bits. Bits of `disp` above the selected size have no effect.
- R4: `scale_log` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R5: An index on register 4 (the stack pointer) sets `out_bad_index`, and that index contributes zero. In every other case `out_bad_index` is 0.
- R6: For a data access (`kind`=0) with no usable override, the segment is SS (2) when the base is enabled and is register 4 or 5. Otherwise it is DS (3). Segment codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5.
- R7: For a data access with `ovr_en`=1 and `ovr_seg` in 0..5, the segment is `ovr_seg`. An `ovr_seg` of 6 or 7 is ignored, and the default from R6 applies.
- R8: For `kind`=1 (stack push or pop) the segment is SS, for `kind`=2 (string destination) it is ES, and for `kind`=3 (instruction fetch) it is CS. In all three cases the override is ignored.
- R9: `out_valid` is `in_valid` delayed by one cycle. An active-low synchronous reset clears all outputs. While `in_valid` is low, the result outputs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| base_en | input | 1 | Base register present |
| base_sel | input | 3 | Base register number |
| idx_en | input | 1 | Index register present |
| idx_sel | input | 3 | Index register number |
| scale_log | input | 2 | Index shift amount |
| disp | input | 32 | Raw displacement |
| disp_size | input | 2 | 0 none, 1 byte, 2 half, 3 word |
| kind | input | 2 | 0 data, 1 stack, 2 string destination, 3 fetch |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 3 | Override segment code |
| gpr_flat | input | 256 | Eight general registers; register k occupies bits [32k+31:32k] |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Effective offset |
| out_seg | output | 3 | Selected segment code |
| out_bad_index | output | 1 | Stack pointer requested as index |

## Verification
The assertions check on every cycle the parts of the behaviour that depend only on the request's kind and index fields. These are the one-cycle valid timing, the fixed segments of the stack, string-destination and fetch kinds, the illegal-index flag, holding the result while idle, and the range of the segment code. The arithmetic cannot be checked that way. This covers the wrapping sum, the sign extension at each displacement size, the scaling, and the default and override choice for data accesses. The bench shows these by sweeping every combination of enables, register numbers, scales and sizes, and every override code for each access kind, against values it computes itself.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int ADDR_W  = 32;
    localparam int NREG    = 8;
    localparam int RSEL_W  = $clog2(NREG);
    localparam int SEG_W   = 3;
    localparam int NUM_SEG = 6;
    localparam int SP_NUM  = 4;
    localparam int FP_NUM  = 5;

    typedef enum logic [SEG_W-1:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef enum logic [1:0] {
        KIND_DATA   = 2'd0,
        KIND_STACK  = 2'd1,
        KIND_STRDST = 2'd2,
        KIND_FETCH  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_B    = 2'd1,
        DSZ_H    = 2'd2,
        DSZ_W    = 2'd3
    } dsz_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] off;
        logic [SEG_W-1:0]  seg;
        logic              bad;
    } res_t;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_pkg::*;
(
    input  logic [ADDR_W-1:0] disp,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] ext
);
    always_comb begin
        ext = '0;
        unique case (dsz_e'(size))
            DSZ_NONE: ext = '0;
            DSZ_B:    ext = {{(ADDR_W-8){disp[7]}}, disp[7:0]};
            DSZ_H:    ext = {{(ADDR_W-16){disp[15]}}, disp[15:0]};
            DSZ_W:    ext = disp;
            default:  ext = '0;
        endcase
    end
endmodule

// File: rtl/ea_index_scaler.sv
module ea_index_scaler
    import ea_pkg::*;
(
    input  logic [NREG*ADDR_W-1:0] regs_flat,
    input  logic                   idx_en,
    input  logic [RSEL_W-1:0]      idx_sel,
    input  logic [1:0]             scale_log,
    output logic [ADDR_W-1:0]      scaled,
    output logic                   bad
);
    logic [ADDR_W-1:0] regs [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_unpack
        assign regs[k] = regs_flat[k*ADDR_W +: ADDR_W];
    end

    always_comb begin
        bad    = idx_en && (idx_sel == RSEL_W'(SP_NUM));
        scaled = '0;
        if (idx_en && !bad) begin
            scaled = regs[idx_sel] << scale_log;
        end
    end
endmodule

// File: rtl/ea_seg_resolve.sv
module ea_seg_resolve
    import ea_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic              ovr_en,
    input  logic [SEG_W-1:0]  ovr_seg,
    input  logic              base_en,
    input  logic [RSEL_W-1:0] base_sel,
    output logic [SEG_W-1:0]  seg
);
    logic ovr_ok;
    logic stack_base;

    always_comb begin
        ovr_ok     = ovr_en && (ovr_seg < SEG_W'(NUM_SEG));
        stack_base = base_en && ((base_sel == RSEL_W'(SP_NUM)) ||
                                 (base_sel == RSEL_W'(FP_NUM)));
        seg = SEG_DS;
        unique case (kind_e'(kind))
            KIND_FETCH:  seg = SEG_CS;
            KIND_STACK:  seg = SEG_SS;
            KIND_STRDST: seg = SEG_ES;
            KIND_DATA: begin
                if (ovr_ok)          seg = ovr_seg;
                else if (stack_base) seg = SEG_SS;
                else                 seg = SEG_DS;
            end
            default: seg = SEG_DS;
        endcase
    end
endmodule

// File: rtl/ea_seg_unit.sv
module ea_seg_unit
    import ea_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   base_en,
    input  logic [RSEL_W-1:0]      base_sel,
    input  logic                   idx_en,
    input  logic [RSEL_W-1:0]      idx_sel,
    input  logic [1:0]             scale_log,
    input  logic [ADDR_W-1:0]      disp,
    input  logic [1:0]             disp_size,
    input  logic [1:0]             kind,
    input  logic                   ovr_en,
    input  logic [SEG_W-1:0]       ovr_seg,
    input  logic [NREG*ADDR_W-1:0] gpr_flat,
    output logic                   out_valid,
    output logic [ADDR_W-1:0]      out_offset,
    output logic [SEG_W-1:0]       out_seg,
    output logic                   out_bad_index
);
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] idx_scaled;
    logic              idx_bad;
    logic [SEG_W-1:0]  seg_sel;
    logic [ADDR_W-1:0] base_val;

    res_t res_d, res_q;

    ea_disp_ext i_disp (
        .disp (disp),
        .size (disp_size),
        .ext  (disp_ext)
    );

    ea_index_scaler i_idx (
        .regs_flat (gpr_flat),
        .idx_en    (idx_en),
        .idx_sel   (idx_sel),
        .scale_log (scale_log),
        .scaled    (idx_scaled),
        .bad       (idx_bad)
    );

    ea_seg_resolve i_seg (
        .kind     (kind),
        .ovr_en   (ovr_en),
        .ovr_seg  (ovr_seg),
        .base_en  (base_en),
        .base_sel (base_sel),
        .seg      (seg_sel)
    );

    always_comb begin
        base_val  = base_en ? gpr_flat[base_sel*ADDR_W +: ADDR_W] : '0;
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.off = base_val + idx_scaled + disp_ext;
            res_d.seg = seg_sel;
            res_d.bad = idx_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid     = res_q.vld;
    assign out_offset    = res_q.off;
    assign out_seg       = res_q.seg;
    assign out_bad_index = res_q.bad;
endmodule

// File: rtl/ea_seg_checker.sv
module ea_seg_checker
    import ea_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              idx_en,
    input logic [RSEL_W-1:0] idx_sel,
    input logic [1:0]        kind,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_offset,
    input logic [SEG_W-1:0]  out_seg,
    input logic              out_bad_index
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_offset) && $stable(out_seg) && $stable(out_bad_index)));
    assert_fetch_code_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'd3) |=> out_seg == 3'd1);
    assert_stack_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'd1) |=> out_seg == 3'd2);
    assert_strdst_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'd2) |=> out_seg == 3'd0);
    assert_bad_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_bad_index == $past(idx_en && idx_sel == 3'd4)));
    assert_seg_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_seg < 3'd6);
endmodule

bind ea_seg_unit ea_seg_checker i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .idx_en        (idx_en),
    .idx_sel       (idx_sel),
    .kind          (kind),
    .out_valid     (out_valid),
    .out_offset    (out_offset),
    .out_seg       (out_seg),
    .out_bad_index (out_bad_index)
);

// File: tb/test_ea_seg_unit.sv
`timescale 1ns/1ps
module test_ea_seg_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         base_en = 1'b0;
    logic [2:0]   base_sel = '0;
    logic         idx_en = 1'b0;
    logic [2:0]   idx_sel = '0;
    logic [1:0]   scale_log = '0;
    logic [31:0]  disp = '0;
    logic [1:0]   disp_size = '0;
    logic [1:0]   kind = '0;
    logic         ovr_en = 1'b0;
    logic [2:0]   ovr_seg = '0;
    logic [255:0] gpr_flat;
    logic         out_valid;
    logic [31:0]  out_offset;
    logic [2:0]   out_seg;
    logic         out_bad_index;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ea_seg_unit i_ea_seg_unit (.*);

    function automatic logic [31:0] gval(input int k);
        return 32'hF000_0000 ^ (32'(k) * 32'h2468_ACE1);
    endfunction

    function automatic logic [31:0] exp_off();
        logic [31:0] b, i, d;
        b = base_en ? gval(int'(base_sel)) : 32'h0;
        i = (idx_en && idx_sel != 3'd4) ? (gval(int'(idx_sel)) << scale_log) : 32'h0;
        case (disp_size)
            2'd1:    d = {{24{disp[7]}}, disp[7:0]};
            2'd2:    d = {{16{disp[15]}}, disp[15:0]};
            2'd3:    d = disp;
            default: d = 32'h0;
        endcase
        return b + i + d;
    endfunction

    function automatic logic [2:0] exp_seg();
        if (kind == 2'd3) return 3'd1;
        if (kind == 2'd1) return 3'd2;
        if (kind == 2'd2) return 3'd0;
        if (ovr_en && ovr_seg <= 3'd5) return ovr_seg;
        if (base_en && (base_sel == 3'd4 || base_sel == 3'd5)) return 3'd2;
        return 3'd3;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input string seg_tag);
        logic [31:0] eo;
        logic [2:0]  es;
        logic        eb;
        eo = exp_off();
        es = exp_seg();
        eb = idx_en && idx_sel == 3'd4;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 valid", 32'(out_valid), 32'd1);
        chk("R1 R2 R3 R4 offset", out_offset, eo);
        chk("R5 bad index", 32'(out_bad_index), 32'(eb));
        chk(seg_tag, 32'(out_seg), 32'(es));
    endtask

    initial begin
        for (int k = 0; k < 8; k++) gpr_flat[k*32 +: 32] = gval(k);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset valid", 32'(out_valid), 32'd0);
        chk("R9 reset offset", out_offset, 32'd0);
        rst_n = 1'b1;
        // Arithmetic sweep: data accesses, no override
        for (int dv = 0; dv < 2; dv++)
        for (int be = 0; be < 2; be++)
        for (int bs = 0; bs < 8; bs++)
        for (int ie = 0; ie < 2; ie++)
        for (int is = 0; is < 8; is++)
        for (int sc = 0; sc < 4; sc++)
        for (int ds = 0; ds < 4; ds++) begin
            base_en = 1'(be); base_sel = 3'(bs);
            idx_en = 1'(ie); idx_sel = 3'(is); scale_log = 2'(sc);
            disp = (dv == 0) ? 32'h7ABC_8F85 : 32'h8765_1278;
            disp_size = 2'(ds);
            kind = 2'd0; ovr_en = 1'b0; ovr_seg = 3'd0;
            run_one("R6 default seg");
        end
        // Segment sweep over kinds and overrides
        for (int kd = 0; kd < 4; kd++)
        for (int oe = 0; oe < 2; oe++)
        for (int os = 0; os < 8; os++)
        for (int be = 0; be < 2; be++)
        for (int bs = 0; bs < 8; bs++) begin
            kind = 2'(kd); ovr_en = 1'(oe); ovr_seg = 3'(os);
            base_en = 1'(be); base_sel = 3'(bs);
            idx_en = 1'b1; idx_sel = 3'((bs + 3) % 8); scale_log = 2'(bs % 4);
            disp = 32'hFFFF_FF00; disp_size = 2'd3;
            run_one(kd == 0 ? "R7 data override seg" : "R8 fixed seg");
        end
        // Idle cycle: valid drops, results hold
        begin
            logic [31:0] held_off;
            logic [2:0]  held_seg;
            held_off = out_offset; held_seg = out_seg;
            in_valid = 1'b0; kind = 2'd0; disp = 32'h1111_1111; base_en = 1'b0;
            @(posedge clk);
            #1;
            chk("R9 idle valid", 32'(out_valid), 32'd0);
            chk("R9 idle offset hold", out_offset, held_off);
            chk("R9 idle seg hold", 32'(out_seg), 32'(held_seg));
        end
        // Reset after activity
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 reset clears valid", 32'(out_valid), 32'd0);
        chk("R9 reset clears offset", out_offset, 32'd0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule